// File: doc/BRIEF.md
# Direction-Selected SPI Master

This block is a serial peripheral master that runs exactly one transaction for each start pulse. A direction input sampled with the start pulse makes the whole transaction either a write, where a parallel word leaves on the serial output most significant bit first, or a read, where bits arriving on the serial input are gathered into a parallel word. The frame length is a parameter. Builds with 29-bit and 27-bit frames are both expected, so the bit counter must handle lengths that are not a power of two.

Clock polarity, clock phase and a half-period divider are taken from the host with the start pulse. They stay fixed until the transaction ends. The active-low chip select opens one half-period before the first serial clock edge and closes one half-period after the last one. A one-cycle done pulse marks the end of the transaction. A received word reaches the parallel output only when the full frame has been sampled.

Top module: `spi_dir_master`

## Requirements
- R1: When `start` is high in a cycle where `busy` is low, `cs_n` goes low and `busy` goes high on the next clock edge.
- R2: With `rd_nwr`=0, `wdata` is sent on `mosi` most significant bit first. A slave sampling on the selected edge receives exactly FRAME_BITS bits equal to `wdata`.
- R3: With `rd_nwr`=1, `rdata` holds the FRAME_BITS `miso` bits sampled on the selected edge, first bit in the most significant position, and `mosi` stays 0 for the whole transaction.
- R4: `rdata` changes only when a read frame has been fully sampled. A write transaction leaves `rdata` unchanged.
- R5: Polarity and phase select the edges. With `cpha`=0, data is sampled on the leading edge, the edge that moves `sclk` away from `cpol`. With `cpha`=1, data is sampled on the trailing edge. There are 2*FRAME_BITS `sclk` edges per transaction.
- R6: While idle, `cs_n`=1, `mosi`=0, and `sclk` follows `cpol` one cycle later.
- R7: Each `sclk` half-period lasts `div`+1 clock cycles. `cs_n` falls `div`+1 cycles before the first `sclk` edge and rises `div`+1 cycles after the last one.
- R8: `done` is high for exactly one cycle, in the same cycle as `cs_n` returns high and `busy` returns low.
- R9: `start` is ignored while `busy` is high. Neither the running transaction's data nor its direction changes, and no further transaction follows.
- R10: The frame length is set by FRAME_BITS. Instances with 27 and 29 bits both transfer full words in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a transaction when idle |
| rd_nwr | input | 1 | 1 = read, 0 = write, sampled with start |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| div | input | DIV_W | Half-period length minus one, in clock cycles |
| wdata | input | FRAME_BITS | Word to send on a write |
| rdata | output | FRAME_BITS | Last word received on a read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume that `cpol` is a clean synchronous input, because the idle serial clock follows it with one cycle of lag. They also assume that `miso` is stable at the clock edge where a sampling `sclk` edge is generated. The bench's slave model changes `miso` only after the sampling edge has been produced. It changes `cpol`, `cpha`, `div` and `rd_nwr` only on falling clock edges, and only while the block is idle or when testing that a start during a transaction is ignored.

// File: rtl/spi_dir_master.sv
module spi_dir_master #(
  parameter int FRAME_BITS = 29,
  parameter int DIV_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  rd_nwr,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic [DIV_W-1:0]      div,
  input  logic [FRAME_BITS-1:0] wdata,
  output logic [FRAME_BITS-1:0] rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso,
  output logic                  cs_n
);
  localparam int N      = FRAME_BITS;
  localparam int HW     = $clog2(2*N+1);
  localparam int BW     = $clog2(N+1);
  localparam logic [HW-1:0] H_END  = HW'(2*N);
  localparam logic [HW-1:0] H_LAST = HW'(2*N-1);
  localparam logic [BW-1:0] B_LAST = BW'(N-1);

  logic [DIV_W-1:0] div_q, divcnt;
  logic [HW-1:0]    hcnt;
  logic [BW-1:0]    nsamp;
  logic [N-1:0]     tx, rx;
  logic             rd_q, cpol_q, cpha_q;

  wire tick = busy && (divcnt == div_q);
  wire fin  = hcnt == H_END;
  wire smp  = hcnt[0] == cpha_q;
  wire skip = !cpha_q && (hcnt == H_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; cs_n <= 1'b1; sclk <= 1'b0; mosi <= 1'b0;
      div_q <= '0; divcnt <= '0; hcnt <= '0; nsamp <= '0;
      tx <= '0; rx <= '0; rdata <= '0;
      rd_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        mosi <= 1'b0;
        if (start) begin
          busy   <= 1'b1;
          cs_n   <= 1'b0;
          div_q  <= div;
          divcnt <= '0;
          hcnt   <= '0;
          nsamp  <= '0;
          rd_q   <= rd_nwr;
          cpol_q <= cpol;
          cpha_q <= cpha;
          rx     <= '0;
          if (!rd_nwr && !cpha) begin
            mosi <= wdata[N-1];
            tx   <= {wdata[N-2:0], 1'b0};
          end else begin
            tx   <= wdata;
          end
        end
      end else if (!tick) begin
        divcnt <= divcnt + 1'b1;
      end else begin
        divcnt <= '0;
        hcnt   <= hcnt + 1'b1;
        if (fin) begin
          busy <= 1'b0;
          cs_n <= 1'b1;
          done <= 1'b1;
          mosi <= 1'b0;
          sclk <= cpol_q;
        end else begin
          sclk <= ~sclk;
          if (smp) begin
            rx    <= {rx[N-2:0], miso};
            nsamp <= nsamp + 1'b1;
            if (rd_q && nsamp == B_LAST) rdata <= {rx[N-2:0], miso};
          end else if (!skip) begin
            mosi <= rd_q ? 1'b0 : tx[N-1];
            tx   <= {tx[N-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_dir_master_chk.sv
module spi_dir_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cpol,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic rd_q
);
  a_r1_cs_opens_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(start) && !$past(busy)));

  a_r3_read_mosi_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q) |-> !mosi);

  a_r6_idle_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (sclk == $past(cpol)));

  a_r6_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !mosi));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(cs_n) && $fell(busy)));
endmodule

bind spi_dir_master spi_dir_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .busy(busy),
  .done(done), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .rd_q(rd_q)
);

// File: tb/sim_spi_dir_master.sv
module sim_slave #(parameter int N = 29) (
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         mosi,
  input  logic         cpol,
  input  logic         cpha,
  input  logic [N-1:0] pat,
  output logic         miso,
  output logic [N-1:0] got,
  output int           cnt
);
  logic cs_prev = 1'b1;
  logic sclk_prev = 1'b0;
  initial begin got = '0; cnt = 0; end
  always @(sclk or cs_n) begin
    if (!cs_n && cs_prev) begin
      cnt = 0; got = '0;
    end else if (!cs_n && sclk !== sclk_prev && ((sclk != cpol) == (cpha == 1'b0))) begin
      got = {got[N-2:0], mosi};
      cnt = cnt + 1;
    end
    cs_prev = cs_n;
    sclk_prev = sclk;
  end
  assign miso = (cnt < N) ? pat[N-1-cnt] : 1'b0;
endmodule

module sim_spi_dir_master;
  localparam int PERIOD = 10;
  localparam int N0 = 29;
  localparam int N1 = 27;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, start1 = 1'b0, rd_nwr = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [7:0] div = '0;
  logic [N0-1:0] wdata = '0, pat0 = '0, rdata, got0;
  logic [N1-1:0] wdata1 = '0, pat1 = '0, rdata1, got1;
  logic busy, done, sclk, mosi, miso, cs_n;
  logic busy1, done1, sclk1, mosi1, miso1, cs_n1;
  int cnt0, cnt1;
  int checks = 0, errors = 0;
  longint t_csf, t_csr, t_first, t_last;
  int ntog;
  logic m_cs = 1'b1, m_sclk = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  spi_dir_master #(.FRAME_BITS(N0), .DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .cpol(cpol), .cpha(cpha),
    .div(div), .wdata(wdata), .rdata(rdata), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));
  sim_slave #(.N(N0)) s0 (.cs_n(cs_n), .sclk(sclk), .mosi(mosi), .cpol(cpol), .cpha(cpha),
    .pat(pat0), .miso(miso), .got(got0), .cnt(cnt0));

  spi_dir_master #(.FRAME_BITS(N1), .DIV_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .rd_nwr(rd_nwr), .cpol(cpol), .cpha(cpha),
    .div(div), .wdata(wdata1), .rdata(rdata1), .busy(busy1), .done(done1),
    .sclk(sclk1), .mosi(mosi1), .miso(miso1), .cs_n(cs_n1));
  sim_slave #(.N(N1)) s1 (.cs_n(cs_n1), .sclk(sclk1), .mosi(mosi1), .cpol(cpol), .cpha(cpha),
    .pat(pat1), .miso(miso1), .got(got1), .cnt(cnt1));

  always @(sclk or cs_n) begin
    if (!cs_n && m_cs) begin t_csf = $time; ntog = 0; end
    else if (cs_n && !m_cs) t_csr = $time;
    else if (!cs_n && sclk !== m_sclk) begin
      if (ntog == 0) t_first = $time;
      t_last = $time;
      ntog = ntog + 1;
    end
    m_cs = cs_n; m_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {cpol, cpha, rd, div[7:0], data[28:0]}
  localparam logic [39:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b0, 8'd1, 29'h1ABCDEF1},
    {1'b0, 1'b0, 1'b1, 8'd2, 29'h0F0F0F0F},
    {1'b0, 1'b1, 1'b0, 8'd0, 29'h15555555},
    {1'b0, 1'b1, 1'b1, 8'd3, 29'h12345678},
    {1'b1, 1'b0, 1'b1, 8'd0, 29'h1FFFFFFE},
    {1'b1, 1'b1, 1'b0, 8'd2, 29'h10000001},
    {1'b1, 1'b1, 1'b1, 8'd1, 29'h0ACE1357}
  };

  task automatic wait_done0();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N0-1:0] keep;
    repeat (3) @(negedge clk);
    chk(cs_n && !busy && !done && !mosi && !sclk, "R6 reset", {cs_n, busy, done, mosi, sclk}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1, "R6 idle sclk follows cpol", sclk, 1);

    foreach (VEC[i]) begin
      logic [28:0] d;
      d = VEC[i][28:0];
      cpol = VEC[i][39]; cpha = VEC[i][38]; rd_nwr = VEC[i][37]; div = VEC[i][36:29];
      wdata = d; pat0 = d;
      keep = rdata;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!cs_n && busy, "R1 cs low and busy", {cs_n, busy}, 2'b01);
      wait_done0();
      chk(cs_n && !busy, "R8 done with release", {cs_n, busy}, 2'b10);
      chk(cnt0 == N0 && ntog == 2*N0, "R5 edge count", ntog, 2*N0);
      chk(t_first - t_csf == longint'((div + 1) * PERIOD), "R7 setup", t_first - t_csf, (div + 1) * PERIOD);
      chk(t_csr - t_last == longint'((div + 1) * PERIOD), "R7 hold", t_csr - t_last, (div + 1) * PERIOD);
      if (rd_nwr) begin
        chk(rdata == d, "R3 R5 read word", rdata, d);
        chk(got0 == '0, "R3 mosi low on read", got0, 0);
      end else begin
        chk(got0 == d, "R2 R5 write word", got0, d);
        chk(rdata == keep, "R4 rdata kept on write", rdata, keep);
      end
      @(negedge clk);
      chk(!done, "R8 done one cycle", done, 0);
    end

    // R9: start during a write is ignored
    cpol = 1'b0; cpha = 1'b0; rd_nwr = 1'b0; div = 8'd1;
    wdata = 29'h0DEAD5A; pat0 = 29'h1FFFFFFF;
    keep = rdata;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    rd_nwr = 1'b1; wdata = 29'h1234567; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done0();
    chk(got0 == 29'h0DEAD5A, "R9 data unchanged by late start", got0, 29'h0DEAD5A);
    chk(rdata == keep, "R9 direction unchanged", rdata, keep);
    repeat (4) @(negedge clk);
    chk(!busy && cs_n, "R9 no extra transaction", busy, 0);

    // R10: 27-bit instance
    rd_nwr = 1'b0; wdata1 = 27'h5A5A5A5; div = 8'd0; cpha = 1'b1;
    @(negedge clk); start1 = 1'b1;
    @(negedge clk); start1 = 1'b0;
    @(negedge clk); while (!done1) @(negedge clk);
    chk(got1 == 27'h5A5A5A5 && cnt1 == N1, "R10 27-bit write", got1, 27'h5A5A5A5);
    rd_nwr = 1'b1; pat1 = 27'h3C3C3C3; cpha = 1'b0;
    @(negedge clk); start1 = 1'b1;
    @(negedge clk); start1 = 1'b0;
    @(negedge clk); while (!done1) @(negedge clk);
    chk(rdata1 == 27'h3C3C3C3, "R10 27-bit read", rdata1, 27'h3C3C3C3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule